// File: doc/BRIEF.md
# SDRAM Per-Bank Command Legality Monitor

This block sits beside a single-data-rate SDRAM command bus and watches it every clock. It keeps a small state machine for each bank. For each cycle it works out which command is on the bus and which bank that command selects. It then judges the command against that bank's own state, and against the state of all banks for the commands that act on the whole device. The verdict and a decoded action code come out in the same cycle as the command.

Only legal commands move a bank's state. Bursts run out by themselves after a set length. A burst with auto-precharge then closes its row, and a closed row returns to idle after a set precharge time. Three timing rules are counted in clock cycles against parameter minimums: the activate-to-column delay, the minimum row-open time, and the spacing between activates.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset every bank reads idle (state code 0), and a deselect (cs_n high) gives illegal low with action 0 (none).
- R2: The command is {ras_n,cas_n,we_n} with cs_n low: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. A no-op with cke low gives action 11 (power-down). A no-op with cke high gives action 0.
- R3: An activate to an idle bank is legal, gives action 1 and makes the bank active (code 1). An activate to a bank that is not idle is illegal.
- R4: A read or write sent fewer than TRCD cycles after its bank's activate is illegal. From TRCD cycles on, it is legal.
- R5: A precharge to an open bank sent fewer than TRAS cycles after the activate is illegal. A legal one gives action 6 and state code 6. The bank then reads idle TRP cycles after that.
- R6: An activate sent fewer than TRRD cycles after any accepted activate is illegal.
- R7: In a plain write (code 2) or read (code 3) burst, a new write, read or precharge to that bank is legal. It cuts the burst short and moves the bank to write, read or precharging.
- R8: In a plain burst, burst stop gives action 7 and returns the bank to active. No-op and deselect leave the burst running. After BURST_LEN cycles the burst ends and the bank is active.
- R9: In a plain burst, mode set, refresh and activate to that bank are illegal.
- R10: In an auto-precharge burst (write code 4, read code 5), every command to that bank except no-op and deselect is illegal.
- R11: a10 high on a write or read gives action 3 or 5 and the matching auto-precharge state. Once BURST_LEN cycles have passed, the bank is precharging, and after TRP more cycles it is idle.
- R12: Mode set (action 8) and refresh are legal only when all banks are idle. Refresh gives action 9 with cke high and action 10 with cke low.
- R13: A command is judged only against the state of the bank its ba field selects, so another bank's burst does not block it.
- R14: An illegal command gives action 15 and changes no bank's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level seen with the command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Auto-precharge select on read or write |
| illegal | output | 1 | Command in this cycle breaks a rule |
| action | output | 4 | Decoded action code for this cycle |
| bank_state | output | 3*2^BA_W | State code of each bank, bank 0 in the low bits |

## Verification
Each bank's state is visible on bank_state one clock after the command that moved it. A wrong transition therefore shows up at once, either in that field or in the verdict on the next command to the same bank. The timing counters have no output of their own. A counter that is off by one shows only as a verdict that flips one cycle too early or too late, so the bench tests each minimum at the last illegal cycle and the first legal one. A sweep puts one bank in every state and sends it every command. This catches any table entry that is wrong, both in the verdict and in the bank's next state.

// File: rtl/sbg_pkg.sv
`timescale 1ns/1ps
package sbg_pkg;

  typedef enum logic [3:0] {
    CMD_DES, CMD_NOP, CMD_MRS, CMD_REF, CMD_PRE,
    CMD_ACT, CMD_WR, CMD_RD, CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ACTIVE   = 3'd1,
    ST_WRITE    = 3'd2,
    ST_READ     = 3'd3,
    ST_WRITE_AP = 3'd4,
    ST_READ_AP  = 3'd5,
    ST_PRECH    = 3'd6
  } bank_st_e;

  typedef enum logic [3:0] {
    AC_NONE       = 4'd0,
    AC_ACTIVATE   = 4'd1,
    AC_WRITE      = 4'd2,
    AC_WRITE_AP   = 4'd3,
    AC_READ       = 4'd4,
    AC_READ_AP    = 4'd5,
    AC_PRECHARGE  = 4'd6,
    AC_TERMINATE  = 4'd7,
    AC_MODE_SET   = 4'd8,
    AC_AUTO_REF   = 4'd9,
    AC_SELF_REF   = 4'd10,
    AC_POWER_DOWN = 4'd11,
    AC_REJECT     = 4'd15
  } action_e;

  function automatic logic is_plain_burst(bank_st_e s);
    return (s == ST_WRITE) || (s == ST_READ);
  endfunction

  function automatic logic is_ap_burst(bank_st_e s);
    return (s == ST_WRITE_AP) || (s == ST_READ_AP);
  endfunction

  // Row open and not locked by an auto-precharge burst
  function automatic logic is_row_open(bank_st_e s);
    return (s == ST_ACTIVE) || is_plain_burst(s);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sbg_cmd_decode.sv
`timescale 1ns/1ps
module sbg_cmd_decode
  import sbg_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DES;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sbg_rules.sv
`timescale 1ns/1ps
module sbg_rules
  import sbg_pkg::*;
(
  input  cmd_e     cmd,
  input  bank_st_e st,
  input  logic     all_idle,
  input  logic     cke,
  input  logic     a10,
  input  logic     trcd_ok,
  input  logic     tras_ok,
  input  logic     trrd_ok,
  output logic     legal,
  output action_e  act
);
  action_e act_raw;

  always_comb begin
    legal   = 1'b1;
    act_raw = AC_NONE;
    unique case (cmd)
      CMD_DES: act_raw = AC_NONE;
      CMD_NOP: act_raw = cke ? AC_NONE : AC_POWER_DOWN;
      CMD_MRS: begin
        legal   = all_idle;
        act_raw = AC_MODE_SET;
      end
      CMD_REF: begin
        legal   = all_idle;
        act_raw = cke ? AC_AUTO_REF : AC_SELF_REF;
      end
      CMD_ACT: begin
        legal   = (st == ST_IDLE) && trrd_ok;
        act_raw = AC_ACTIVATE;
      end
      CMD_WR: begin
        legal   = is_row_open(st) && trcd_ok;
        act_raw = a10 ? AC_WRITE_AP : AC_WRITE;
      end
      CMD_RD: begin
        legal   = is_row_open(st) && trcd_ok;
        act_raw = a10 ? AC_READ_AP : AC_READ;
      end
      CMD_PRE: begin
        if (is_ap_burst(st)) begin
          legal = 1'b0;
        end else if (is_row_open(st)) begin
          legal   = tras_ok;
          act_raw = AC_PRECHARGE;
        end
      end
      CMD_BST: begin
        if (is_ap_burst(st)) legal = 1'b0;
        else if (is_plain_burst(st)) act_raw = AC_TERMINATE;
      end
      default: act_raw = AC_NONE;
    endcase
    act = legal ? act_raw : AC_REJECT;
  end
endmodule

// File: rtl/sbg_bank_fsm.sv
`timescale 1ns/1ps
module sbg_bank_fsm
  import sbg_pkg::*;
#(
  parameter int TRCD      = 2,
  parameter int TRAS      = 5,
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  cmd_e     cmd,
  input  logic     a10,
  output bank_st_e state,
  output logic     trcd_ok,
  output logic     tras_ok
);
  localparam int AGE_MAX = (TRCD > TRAS) ? TRCD : TRAS;

  bank_st_e        state_q;
  logic [CNT_W-1:0] age_q;
  logic [CNT_W-1:0] cnt_q;
  logic            cnt_last;

  assign state    = state_q;
  assign trcd_ok  = age_q >= CNT_W'(TRCD);
  assign tras_ok  = age_q >= CNT_W'(TRAS);
  assign cnt_last = cnt_q <= CNT_W'(1);

  // Cycles since the last activate, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (go && cmd == CMD_ACT) begin
      age_q <= CNT_W'(1);
    end else if (age_q < CNT_W'(AGE_MAX)) begin
      age_q <= age_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (go) begin
      unique case (cmd)
        CMD_ACT: state_q <= ST_ACTIVE;
        CMD_WR: begin
          state_q <= a10 ? ST_WRITE_AP : ST_WRITE;
          cnt_q   <= CNT_W'(BURST_LEN);
        end
        CMD_RD: begin
          state_q <= a10 ? ST_READ_AP : ST_READ;
          cnt_q   <= CNT_W'(BURST_LEN);
        end
        CMD_PRE: begin
          if (is_row_open(state_q)) begin
            state_q <= ST_PRECH;
            cnt_q   <= CNT_W'(TRP);
          end
        end
        CMD_BST: begin
          if (is_plain_burst(state_q)) state_q <= ST_ACTIVE;
        end
        default: state_q <= state_q;
      endcase
    end else begin
      unique case (state_q)
        ST_WRITE, ST_READ: begin
          if (cnt_last) state_q <= ST_ACTIVE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_WRITE_AP, ST_READ_AP: begin
          if (cnt_last) begin
            state_q <= ST_PRECH;
            cnt_q   <= CNT_W'(TRP);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_PRECH: begin
          if (cnt_last) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= state_q;
      endcase
    end
  end

  // R5
  prech_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_PRECH && state_q != ST_PRECH) |-> state_q == ST_IDLE);

  // R4
  trcd_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (cmd == CMD_RD || cmd == CMD_WR)) |-> age_q >= CNT_W'(TRCD));

  // R10
  ap_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ap_burst(state_q) |-> !go);

endmodule

// File: rtl/sdram_bank_guard.sv
`timescale 1ns/1ps
module sdram_bank_guard
  import sbg_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int TRCD      = 2,
  parameter int TRAS      = 5,
  parameter int TRRD      = 2,
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic                    a10,
  output logic                    illegal,
  output logic [3:0]              action,
  output logic [3*(1<<BA_W)-1:0]  bank_state
);
  localparam int NBANKS  = 1 << BA_W;
  localparam int CNT_W   = $clog2(max3(max3(TRCD, TRAS, TRRD), TRP, BURST_LEN) + 2);
  localparam int GAP_MAX = (TRRD < 1) ? 1 : TRRD;

  cmd_e             cmd;
  bank_st_e         st [NBANKS];
  logic [NBANKS-1:0] trcd_ok_b, tras_ok_b, go_b, idle_b;
  logic             legal;
  action_e          act;
  logic             all_idle;
  logic             act_go;
  logic [CNT_W-1:0] gap_q;
  logic             trrd_ok;

  sbg_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar i = 0; i < NBANKS; i++) begin : g_bank
    assign go_b[i] = legal && (ba == BA_W'(i)) &&
                     (cmd inside {CMD_ACT, CMD_WR, CMD_RD, CMD_PRE, CMD_BST});
    assign idle_b[i] = (st[i] == ST_IDLE);
    assign bank_state[3*i +: 3] = st[i];

    sbg_bank_fsm #(
      .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
    ) u_fsm (
      .clk(clk), .rst_n(rst_n), .go(go_b[i]), .cmd(cmd), .a10(a10),
      .state(st[i]), .trcd_ok(trcd_ok_b[i]), .tras_ok(tras_ok_b[i])
    );
  end

  assign all_idle = &idle_b;

  // Spacing since the most recent accepted activate to any bank
  assign act_go  = legal && (cmd == CMD_ACT);
  assign trrd_ok = gap_q >= CNT_W'(TRRD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= CNT_W'(GAP_MAX);
    end else if (act_go) begin
      gap_q <= CNT_W'(1);
    end else if (gap_q < CNT_W'(GAP_MAX)) begin
      gap_q <= gap_q + CNT_W'(1);
    end
  end

  sbg_rules u_rules (
    .cmd(cmd), .st(st[ba]), .all_idle(all_idle), .cke(cke), .a10(a10),
    .trcd_ok(trcd_ok_b[ba]), .tras_ok(tras_ok_b[ba]), .trrd_ok(trrd_ok),
    .legal(legal), .act(act)
  );

  assign illegal = !legal;
  assign action  = act;

  // R6
  trrd_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> gap_q >= CNT_W'(TRRD));

  // R12
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (action == AC_MODE_SET) |-> all_idle);

  // R14
  reject_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (action == AC_REJECT && go_b == '0));

endmodule

// File: tb/sdram_bank_guard_test.sv
`timescale 1ns/1ps
module sdram_bank_guard_test;
  localparam int TRCD = 2, TRAS = 5, TRRD = 2, TRP = 3, BL = 4;
  // Bench command codes {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_MRS = 4'b0000,
                         C_REF = 4'b0001, C_PRE = 4'b0010, C_ACT = 4'b0011,
                         C_WR = 4'b0100, C_RD = 4'b0101, C_BST = 4'b0110;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic illegal;
  logic [3:0] action;
  logic [11:0] bank_state;
  int errors = 0, checks = 0;
  logic cap_ill;
  logic [3:0] cap_act;

  always #10 clk = ~clk;

  sdram_bank_guard #(.BA_W(2), .TRCD(TRCD), .TRAS(TRAS), .TRRD(TRRD), .TRP(TRP),
                     .BURST_LEN(BL)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .illegal(illegal), .action(action),
    .bank_state(bank_state));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int st_of(input int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  task automatic step(input logic [3:0] c, input int b, input logic av, input logic kv);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = 2'(b); a10 = av; cke = kv;
    #2;
    cap_ill = illegal;
    cap_act = action;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; {cs_n, ras_n, cas_n, we_n} = C_DES; cke = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic open_bank0();
    step(C_ACT, 0, 0, 1);
    repeat (6) step(C_NOP, 0, 0, 1);
  endtask

  function automatic bit exp_legal(input int s, input logic [3:0] c);
    bit ap, open;
    ap   = (s == 4 || s == 5);
    open = (s == 1 || s == 2 || s == 3);
    case (c)
      C_DES, C_NOP: return 1;
      C_MRS, C_REF: return s == 0;
      C_ACT:        return s == 0;
      C_WR, C_RD:   return open;
      default:      return !ap;
    endcase
  endfunction

  function automatic int exp_next(input int s, input logic [3:0] c, input bit ok);
    if (!ok) return s;
    case (c)
      C_ACT: return 1;
      C_WR:  return 2;
      C_RD:  return 3;
      C_PRE: return (s >= 1 && s <= 3) ? 6 : s;
      C_BST: return (s == 2 || s == 3) ? 1 : s;
      default: return s;
    endcase
  endfunction

  function automatic string sweep_tag(input int s, input logic [3:0] c);
    if (s == 4 || s == 5) return "R10";
    if (s == 2 || s == 3) begin
      if (c == C_RD || c == C_WR || c == C_PRE) return "R7";
      if (c == C_BST || c == C_NOP || c == C_DES) return "R8";
      return "R9";
    end
    if (c == C_MRS || c == C_REF) return "R12";
    return "R3";
  endfunction

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] cmds [9];
    cmds = '{C_DES, C_NOP, C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD, C_BST};
    do_reset();
    #2;
    // R1
    for (int b = 0; b < 4; b++) chk("R1 reset state", st_of(b), 0);
    chk("R1 deselect illegal", int'(illegal), 0);
    chk("R1 deselect action", int'(action), 0);

    // R2 / R12
    step(C_NOP, 0, 0, 0);  chk("R2 power-down", int'(cap_act), 11);
    step(C_NOP, 0, 0, 1);  chk("R2 plain no-op", int'(cap_act), 0);
    step(C_REF, 0, 0, 1);  chk("R12 auto refresh", int'(cap_act), 9);
    step(C_REF, 0, 0, 0);  chk("R12 self refresh", int'(cap_act), 10);
    step(C_MRS, 0, 0, 1);  chk("R12 mode set idle", int'(cap_act), 8);

    // R4 / R6 / R3
    step(C_ACT, 1, 0, 1);  chk("R3 activate action", int'(cap_act), 1);
    chk("R3 active state", st_of(1), 1);
    step(C_ACT, 2, 0, 1);  chk("R6 activate too soon", int'(cap_ill), 1);
    chk("R14 bank2 unchanged", st_of(2), 0);
    step(C_RD, 1, 0, 1);   chk("R4 read at trcd", int'(cap_ill), 0);
    chk("R4 read state", st_of(1), 3);
    step(C_ACT, 2, 0, 1);  chk("R6 activate after trrd", int'(cap_ill), 0);
    step(C_WR, 2, 0, 1);   chk("R4 write before trcd", int'(cap_ill), 1);
    chk("R14 reject code", int'(cap_act), 15);
    step(C_WR, 2, 0, 1);   chk("R4 write at trcd", int'(cap_ill), 0);
    step(C_MRS, 0, 0, 1);  chk("R12 mode set busy", int'(cap_ill), 1);
    step(C_ACT, 1, 0, 1);  chk("R3 activate open bank", int'(cap_ill), 1);

    // R5 tRAS and tRP
    do_reset();
    step(C_ACT, 0, 0, 1);
    repeat (3) step(C_NOP, 0, 0, 1);
    step(C_PRE, 0, 0, 1);  chk("R5 precharge before tras", int'(cap_ill), 1);
    step(C_PRE, 0, 0, 1);  chk("R5 precharge at tras", int'(cap_act), 6);
    chk("R5 precharging", st_of(0), 6);
    repeat (TRP - 1) step(C_NOP, 0, 0, 1);
    chk("R5 still precharging", st_of(0), 6);
    step(C_NOP, 0, 0, 1);  chk("R5 idle after trp", st_of(0), 0);

    // R11 auto-precharge burst run-out, R13 other bank
    do_reset();
    step(C_ACT, 3, 0, 1);
    repeat (6) step(C_NOP, 3, 0, 1);
    step(C_RD, 3, 1, 1);   chk("R11 read ap action", int'(cap_act), 5);
    chk("R11 read ap state", st_of(3), 5);
    step(C_ACT, 0, 0, 1);  chk("R13 other bank activate", int'(cap_ill), 0);
    step(C_RD, 3, 0, 1);   chk("R10 read in ap", int'(cap_ill), 1);
    step(C_NOP, 3, 0, 1);  chk("R11 ap still bursting", st_of(3), 5);
    step(C_NOP, 3, 0, 1);  chk("R11 ap to precharge", st_of(3), 6);
    repeat (TRP) step(C_NOP, 3, 0, 1);
    chk("R11 ap to idle", st_of(3), 0);

    // R8 plain burst run-out, R11 write ap action
    do_reset();
    open_bank0();
    step(C_WR, 0, 1, 1);   chk("R11 write ap action", int'(cap_act), 3);
    do_reset();
    open_bank0();
    step(C_WR, 0, 0, 1);   chk("R8 write action", int'(cap_act), 2);
    repeat (BL - 1) step(C_DES, 0, 0, 1);
    chk("R8 burst running", st_of(0), 2);
    step(C_DES, 0, 0, 1);  chk("R8 burst ended", st_of(0), 1);

    // Sweep: every state of bank 0 against every command
    for (int s = 0; s < 7; s++) begin
      for (int k = 0; k < 9; k++) begin
        bit ok;
        do_reset();
        if (s != 0) open_bank0();
        case (s)
          2: step(C_WR, 0, 0, 1);
          3: step(C_RD, 0, 0, 1);
          4: step(C_WR, 0, 1, 1);
          5: step(C_RD, 0, 1, 1);
          6: step(C_PRE, 0, 0, 1);
          default: ;
        endcase
        chk("R3 sweep setup", st_of(0), s);
        ok = exp_legal(s, cmds[k]);
        step(cmds[k], 0, 0, 1);
        chk(sweep_tag(s, cmds[k]), int'(cap_ill), int'(!ok));
        chk(ok ? sweep_tag(s, cmds[k]) : "R14", st_of(0), exp_next(s, cmds[k], ok));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule